// File: doc/BRIEF.md
# DMA Request Arbiter and Bus Handshake

This block decides which of several peripheral channels gets the next DMA service. Each channel can ask for service on a hardware request pin or through a software request register. Hardware requests pass through a two-stage synchronizer and are then gated by a per-channel mask. Software requests are not affected by the mask. Among the pending requests, the lowest-numbered channel wins.

When any request is pending, the block raises a bus hold request and waits for the host to acknowledge it. In the cycle the acknowledge is sampled, the block latches the winning channel. It then drives that channel's acknowledge line and keeps it, together with the hold request, until a service-done pulse arrives. After the pulse it releases the bus. Command inputs set the active level of the request pins and of the acknowledge lines. The block carries no data stream, so every pin is a plain control or status signal.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `hold_req` and `sel_valid` are 0 and every `dack` line sits at its inactive level. Every mask bit resets to 1 (channel ignored) and the software request register resets to 0, so a hardware request gives no `hold_req`.
- R2: A hardware request on an unmasked channel raises `hold_req` on the third rising edge after the pin changes (two synchronizer stages plus one state register). `hold_req` is still low after the second edge.
- R3: Writing the software request register (`swreq_wr`, bit i = channel i) with a nonzero value raises `hold_req` on the second rising edge after the write edge, whatever the mask holds.
- R4: No `dack` line becomes active before `hold_ack` has been sampled high while `hold_req` is asserted. The grant appears on the edge that samples `hold_ack`.
- R5: The granted channel is the lowest index among pending requests, where pending means (synchronized hardware request AND NOT mask bit) OR software request bit. `sel_ch` gives that index in binary.
- R6: During service, `sel_ch`, the active `dack` line and `hold_req` stay constant whatever happens on the request pins, until `svc_done`.
- R7: `svc_done` during service makes `sel_valid` and `hold_req` low on the next edge, with every `dack` line inactive. It also clears the software request bit of the served channel, so the remaining software requests are granted one after another in ascending channel order.
- R8: `req_pol` = 0 makes the request pins active high. `req_pol` = 1 makes them active low.
- R9: `ack_pol` = 0 makes the `dack` lines active low. `ack_pol` = 1 makes them active high. At most one line is active, and only while `sel_valid` is 1.
- R10: If every pending request goes away before `hold_ack` is seen, `hold_req` drops again without any grant.
- R11: A hardware request on a channel whose mask bit is 1 is never granted. A `mask_wr` write replaces the whole mask (bit i = channel i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dreq_in | input | NCH | Asynchronous hardware request pins |
| req_pol | input | 1 | Request pin level: 0 = active high, 1 = active low |
| ack_pol | input | 1 | Acknowledge level: 0 = active low, 1 = active high |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | NCH | New mask value, 1 = ignore channel |
| swreq_wr | input | 1 | Write strobe for the software request register |
| swreq_wdata | input | NCH | New software request bits |
| hold_ack | input | 1 | Bus hold acknowledge from the host |
| svc_done | input | 1 | One-cycle pulse marking the end of the current service |
| hold_req | output | 1 | Bus hold request |
| dack | output | NCH | Per-channel acknowledge, level set by ack_pol |
| sel_ch | output | CW | Index of the channel being served |
| sel_valid | output | 1 | High while a channel is being served |

## Verification
The bench sweeps every mask value against every nonzero hardware request pattern, under all four combinations of request and acknowledge polarity. This catches a priority encoder that picks the wrong end, a mask that is inverted or bypassed, and a polarity inversion applied to the wrong side. In each grant, every request line is then turned on to test whether a design that re-arbitrates during service would switch to the higher-priority channel. The same requests are then pulled back before any acknowledge, which exposes a hold request that stays stuck high. Software request patterns are served to completion, which shows whether the served bit is cleared: a design that forgets to clear it would grant the same channel again without end. The edge counts for the hold request are checked to the cycle, so a missing or extra synchronizer stage shows up.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WAIT  = 2'd1,
    ARB_SERVE = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_dreq_sync.sv
// Multi-stage synchronizer per request pin, followed by polarity correction.
module dma_dreq_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_pol,
  input  logic [NCH-1:0] raw_in,
  output logic [NCH-1:0] req_active
);
  logic [NCH-1:0] synced;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], raw_in[ch]};
    end
    assign synced[ch] = chain[STAGES-1];
  end

  // req_pol = 1: a low level on the pin means the channel is requesting
  assign req_active = synced ^ {NCH{req_pol}};
endmodule

// File: rtl/dma_req_regs.sv
// Mask and software request registers.
module dma_req_regs #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mask_wr,
  input  logic [NCH-1:0] mask_wdata,
  input  logic           swreq_wr,
  input  logic [NCH-1:0] swreq_wdata,
  input  logic           clr_en,
  input  logic [CW-1:0]  clr_idx,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] swreq_q
);
  logic [NCH-1:0] swreq_nxt;

  always_comb begin
    swreq_nxt = swreq_wr ? swreq_wdata : swreq_q;
    if (clr_en) swreq_nxt[clr_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      swreq_q <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      swreq_q <= swreq_nxt;
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
// Fixed priority: the lowest set index wins.
module dma_prio_pick #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CW-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] dreq_in,
  input  logic           req_pol,
  input  logic           ack_pol,
  input  logic           mask_wr,
  input  logic [NCH-1:0] mask_wdata,
  input  logic           swreq_wr,
  input  logic [NCH-1:0] swreq_wdata,
  input  logic           hold_ack,
  input  logic           svc_done,
  output logic           hold_req,
  output logic [NCH-1:0] dack,
  output logic [CW-1:0]  sel_ch,
  output logic           sel_valid
);
  arb_state_e     state_q, state_d;
  logic [CW-1:0]  sel_q;
  logic [NCH-1:0] hw_active, mask_q, swreq_q, pending, grant;
  logic           any_pending, finish;
  logic [CW-1:0]  win_idx;

  dma_dreq_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_pol(req_pol),
    .raw_in(dreq_in), .req_active(hw_active)
  );

  assign finish = (state_q == ARB_SERVE) && svc_done;

  dma_req_regs #(.NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .swreq_wr(swreq_wr), .swreq_wdata(swreq_wdata),
    .clr_en(finish), .clr_idx(sel_q),
    .mask_q(mask_q), .swreq_q(swreq_q)
  );

  // Software requests bypass the mask
  assign pending = (hw_active & ~mask_q) | swreq_q;

  dma_prio_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .req(pending), .any(any_pending), .idx(win_idx)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE:  if (any_pending) state_d = ARB_WAIT;
      ARB_WAIT: begin
        if (!any_pending)   state_d = ARB_IDLE;
        else if (hold_ack)  state_d = ARB_SERVE;
      end
      ARB_SERVE: if (svc_done) state_d = ARB_IDLE;
      default:   state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ARB_IDLE;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ARB_WAIT && any_pending && hold_ack) sel_q <= win_idx;
    end
  end

  always_comb begin
    grant = '0;
    if (state_q == ARB_SERVE) grant[sel_q] = 1'b1;
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_dack
    assign dack[gi] = ack_pol ? grant[gi] : ~grant[gi];
  end

  assign hold_req  = (state_q != ARB_IDLE);
  assign sel_valid = (state_q == ARB_SERVE);
  assign sel_ch    = sel_q;
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           ack_pol,
  input logic           hold_ack,
  input logic           svc_done,
  input logic           hold_req,
  input logic [NCH-1:0] dack,
  input logic [CW-1:0]  sel_ch,
  input logic           sel_valid
);
  logic [NCH-1:0] ack_on;
  assign ack_on = ack_pol ? dack : ~dack;

  // R4: a grant only follows a sampled hold acknowledge
  a_r4_grant_after_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_valid) |-> $past(hold_ack));

  // R6: the selection does not move during service
  a_r6_sel_stable: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && $past(sel_valid)) |-> $stable(sel_ch));

  // R7: the done pulse releases the bus
  a_r7_done_release: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && svc_done) |=> (!sel_valid && !hold_req));

  // R9: exactly one acknowledge line is active during service, none otherwise
  a_r9_ack_count: assert property (@(posedge clk) disable iff (rst)
    $countones(ack_on) == (sel_valid ? 1 : 0));

  // R1: without a hold request no acknowledge is active
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !hold_req |-> (ack_on == '0));
endmodule

bind dma_req_arbiter dma_arb_checker #(.NCH(NCH), .CW(CW)) u_arb_chk (
  .clk(clk), .rst(rst), .ack_pol(ack_pol), .hold_ack(hold_ack),
  .svc_done(svc_done), .hold_req(hold_req), .dack(dack),
  .sel_ch(sel_ch), .sel_valid(sel_valid)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] dreq_in = '0, mask_wdata = '0, swreq_wdata = '0;
  logic req_pol = 1'b0, ack_pol = 1'b0, mask_wr = 1'b0, swreq_wr = 1'b0;
  logic hold_ack = 1'b0, svc_done = 1'b0;
  logic hold_req, sel_valid;
  logic [NCH-1:0] dack;
  logic [1:0] sel_ch;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dma_req_arbiter #(.NCH(NCH), .SYNC_STAGES(2)) i_dma_req_arbiter (
    .clk(clk), .rst(rst), .dreq_in(dreq_in), .req_pol(req_pol),
    .ack_pol(ack_pol), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .swreq_wr(swreq_wr), .swreq_wdata(swreq_wdata), .hold_ack(hold_ack),
    .svc_done(svc_done), .hold_req(hold_req), .dack(dack),
    .sel_ch(sel_ch), .sel_valid(sel_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int lowest(input int v);
    for (int i = 0; i < NCH; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [NCH-1:0] dack_exp(input int ch, input logic ap);
    logic [NCH-1:0] g = '0;
    if (ch >= 0) g[ch] = 1'b1;
    return ap ? g : ~g;
  endfunction

  task automatic set_mask(input logic [NCH-1:0] m);
    mask_wdata = m; mask_wr = 1'b1;
    step(1);
    mask_wr = 1'b0;
  endtask

  task automatic hw_trial(input int m, input int p, input logic rp, input logic ap);
    logic [NCH-1:0] idle_lvl, act;
    int w;
    idle_lvl = rp ? '1 : '0;
    w = lowest(p & ~m);
    set_mask(m[NCH-1:0]);
    dreq_in = rp ? ~p[NCH-1:0] : p[NCH-1:0];
    step(2);
    chk(hold_req == 1'b0, "R2 hold_req low after 2 edges", hold_req, 0);
    step(1);
    chk(hold_req == (w >= 0), "R2/R11 hold_req after 3 edges", hold_req, w >= 0);
    if (w >= 0) begin
      step(2);
      chk(dack == dack_exp(-1, ap), "R4 no dack before hold_ack", dack, dack_exp(-1, ap));
      hold_ack = 1'b1;
      step(1);
      chk(sel_valid && sel_ch == w, "R5 winner", sel_ch, w);
      chk(dack == dack_exp(w, ap), "R9 dack level", dack, dack_exp(w, ap));
      act = '1;
      dreq_in = rp ? ~act : act;
      step(2);
      chk(sel_ch == w && dack == dack_exp(w, ap) && hold_req, "R6 held during service",
          sel_ch, w);
      svc_done = 1'b1; hold_ack = 1'b0; dreq_in = idle_lvl;
      step(1);
      svc_done = 1'b0;
      chk(!hold_req && !sel_valid && dack == dack_exp(-1, ap), "R7 release after done",
          hold_req, 0);
      step(4);
      chk(!hold_req, "R10 hold_req drops when requests vanish", hold_req, 0);
    end else begin
      dreq_in = idle_lvl;
      step(3);
    end
  endtask

  task automatic sw_trial(input int s, input logic ap);
    int rem, w, waited;
    set_mask('1);
    swreq_wdata = s[NCH-1:0]; swreq_wr = 1'b1;
    step(1);
    swreq_wr = 1'b0;
    chk(!hold_req, "R3 hold_req low one edge after write", hold_req, 0);
    step(1);
    chk(hold_req, "R3 hold_req two edges after write", hold_req, 1);
    hold_ack = 1'b1;
    rem = s;
    while (rem != 0) begin
      w = lowest(rem);
      waited = 0;
      while (!sel_valid && waited < 6) begin step(1); waited++; end
      chk(sel_valid && sel_ch == w, "R7 software grant order", sel_ch, w);
      chk(dack == dack_exp(w, ap), "R9 software dack", dack, dack_exp(w, ap));
      svc_done = 1'b1;
      step(1);
      svc_done = 1'b0;
      rem = rem & ~(1 << w);
      chk(!sel_valid, "R7 sel_valid low after done", sel_valid, 0);
    end
    hold_ack = 1'b0;
    step(3);
    chk(!hold_req, "R7 software bits cleared", hold_req, 0);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    chk(!hold_req && !sel_valid, "R1 reset outputs idle", hold_req, 0);
    chk(dack == 4'hF, "R1 dack inactive after reset", dack, 4'hF);
    dreq_in = '1;
    step(5);
    chk(!hold_req, "R1 mask ignores all after reset", hold_req, 0);
    dreq_in = '0;
    step(3);

    for (int pol = 0; pol < 4; pol++) begin
      req_pol = pol[0]; ack_pol = pol[1];
      dreq_in = req_pol ? '1 : '0;
      set_mask('1);
      step(4);
      chk(!hold_req, "R8 idle level after polarity change", hold_req, 0);
      for (int m = 0; m < 16; m++)
        for (int p = 1; p < 16; p++)
          hw_trial(m, p, req_pol, ack_pol);
    end

    req_pol = 1'b0; dreq_in = '0;
    step(3);
    for (int s = 1; s < 16; s++) sw_trial(s, ack_pol);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule